// File: doc/BRIEF.md
# Masked Two-Table Vector Permute Unit

This unit builds a 512-bit result vector element by element. Each element is taken from one of two tables. Table zero is the current destination vector, which the result replaces. Table one is a second source vector. An index vector, with one index per element, chooses the table and the position within that table. The element width (16, 32 or 64 bits) and the active vector length (128, 256 or 512 bits) are chosen for each operation.

A per-element write mask either passes the permuted value through, keeps the old destination value (merge), or clears the element (zero). For 32-bit and 64-bit elements, a broadcast option makes every element that picks table one take the lowest element of the second source. The unit captures an operation when `in_valid` is high and presents the registered result one clock later.

Top module: `perm2t_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` holds the value for that operation. When `in_valid` is low at an edge, `out_valid` is low after it. A synchronous active-high `rst` clears `out_valid` and `result`.
- R2: `elem_sz` code 0 selects 16-bit elements, code 1 selects 32-bit elements, and codes 2 and 3 select 64-bit elements. `vec_len` code 0 selects 128 bits, code 1 selects 256 bits, and codes 2 and 3 select 512 bits. The number of active elements is the length divided by the element width.
- R3: Let P be log2 of the active element count. Bits [P-1:0] of each index element give the position within a table, and bit P selects the table. For example, 32-bit elements at 128 bits use bits [1:0] for the position and bit 2 for the table.
- R4: When the table bit is 0, the element comes from `dst_in` as it was presented with the operation. When the table bit is 1, the element comes from `src_b`. Every element reads the unmodified inputs.
- R5: When `mask_on` is 1 and `zero_fill` is 0, an element whose `lane_mask` bit is 0 keeps its `dst_in` value.
- R6: When `mask_on` is 1 and `zero_fill` is 1, an element whose mask bit is 0 becomes zero. When `mask_on` is 0, every active element gets its permuted value, whatever `lane_mask` holds.
- R7: When `bcast` is 1 and the elements are 32 or 64 bits wide, an element whose table bit is 1 takes element 0 of `src_b`. Elements that pick table zero are not affected.
- R8: With 16-bit elements, `bcast` has no effect.
- R9: All result bits at and above the active length are zero. Mask bits at or above the active element count have no effect.
- R10: Several elements may name the same source element. Index bits above the table bit have no effect.
- R11: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| elem_sz | input | 2 | Element width code (R2) |
| vec_len | input | 2 | Active vector length code (R2) |
| mask_on | input | 1 | Enables the per-element mask |
| zero_fill | input | 1 | 1 clears masked-off elements, 0 merges them |
| bcast | input | 1 | Broadcast element 0 of src_b for table-one picks |
| lane_mask | input | 32 | One mask bit per element, bit j for element j |
| idx_vec | input | 512 | Index elements, same width as the data elements |
| dst_in | input | 512 | Old destination vector (table zero) |
| src_b | input | 512 | Second source vector (table one) |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered permuted vector |

## Verification
Each operation's result is due exactly one rising edge after the edge that captures it. The driver task applies an operation at a falling edge and pushes its expected vector into a queue. The monitor samples at every falling edge. Whenever it sees `out_valid`, it pops the oldest expectation and compares it, so back-to-back operations must arrive in order with no gap or extra cycle. Reset values and the hold of `result` are checked at falling edges during idle stretches.

// File: rtl/perm2t_pkg.sv
package perm2t_pkg;
  localparam int VEC_W    = 512;
  localparam int MIN_EW   = 16;
  localparam int MAX_LN   = VEC_W / MIN_EW;

  typedef enum logic [1:0] {
    ESZ_16 = 2'd0,
    ESZ_32 = 2'd1,
    ESZ_64 = 2'd2
  } esz_e;

  typedef enum logic [1:0] {
    VL_Q = 2'd0,
    VL_H = 2'd1,
    VL_F = 2'd2
  } vlen_e;
endpackage

// File: rtl/perm2t_vmask.sv
module perm2t_vmask #(
  parameter int DW = 512
) (
  input  logic [1:0]    vec_len,
  output logic [DW-1:0] keep
);
  localparam int QW = DW / 4;

  int span;

  always_comb begin
    case (vec_len)
      2'd0:    span = QW;
      2'd1:    span = QW * 2;
      default: span = DW;
    endcase
    keep = {DW{1'b1}} >> (DW - span);
  end
endmodule

// File: rtl/perm2t_lanes.sv
module perm2t_lanes #(
  parameter int DW    = 512,
  parameter int EW    = 32,
  parameter bit BC_OK = 1'b1,
  localparam int N    = DW / EW,
  localparam int IW   = $clog2(N)
) (
  input  logic [1:0]    vec_len,
  input  logic          mask_on,
  input  logic          zero_fill,
  input  logic          bcast,
  input  logic [N-1:0]  lane_mask,
  input  logic [DW-1:0] idx_vec,
  input  logic [DW-1:0] dst_in,
  input  logic [DW-1:0] src_b,
  output logic [DW-1:0] lanes_out
);
  logic [1:0] drop;

  always_comb begin
    case (vec_len)
      2'd0:    drop = 2'd2;
      2'd1:    drop = 2'd1;
      default: drop = 2'd0;
    endcase
  end

  for (genvar j = 0; j < N; j++) begin : g_lane
    logic [IW:0]   ie;
    logic [IW-1:0] pos;
    logic          tsel;
    logic [EW-1:0] pick;
    logic [EW-1:0] lane;

    always_comb begin
      ie   = (IW+1)'(idx_vec >> (j * EW));
      pos  = ie[IW-1:0] & ({IW{1'b1}} >> drop);
      tsel = ie[IW - int'(drop)];
      if (tsel) begin
        if (BC_OK && bcast) pick = src_b[EW-1:0];
        else                pick = src_b[pos*EW +: EW];
      end else begin
        pick = dst_in[pos*EW +: EW];
      end
      if (!mask_on || lane_mask[j]) lane = pick;
      else if (zero_fill)           lane = '0;
      else                          lane = dst_in[j*EW +: EW];
    end

    assign lanes_out[j*EW +: EW] = lane;
  end
endmodule

// File: rtl/perm2t_unit.sv
module perm2t_unit
  import perm2t_pkg::*;
#(
  parameter int DW = VEC_W,
  localparam int ML = DW / MIN_EW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    elem_sz,
  input  logic [1:0]    vec_len,
  input  logic          mask_on,
  input  logic          zero_fill,
  input  logic          bcast,
  input  logic [ML-1:0] lane_mask,
  input  logic [DW-1:0] idx_vec,
  input  logic [DW-1:0] dst_in,
  input  logic [DW-1:0] src_b,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int NW = 3;

  logic [DW-1:0] by_w [NW];
  logic [DW-1:0] keep;
  logic [DW-1:0] nxt;

  for (genvar w = 0; w < NW; w++) begin : g_width
    localparam int EW = MIN_EW << w;
    localparam int NL = DW / EW;
    perm2t_lanes #(
      .DW    (DW),
      .EW    (EW),
      .BC_OK (w != 0)
    ) u_lanes (
      .vec_len   (vec_len),
      .mask_on   (mask_on),
      .zero_fill (zero_fill),
      .bcast     (bcast),
      .lane_mask (lane_mask[NL-1:0]),
      .idx_vec   (idx_vec),
      .dst_in    (dst_in),
      .src_b     (src_b),
      .lanes_out (by_w[w])
    );
  end

  perm2t_vmask #(.DW(DW)) u_vmask (
    .vec_len (vec_len),
    .keep    (keep)
  );

  always_comb begin
    case (elem_sz)
      ESZ_16:  nxt = by_w[0];
      ESZ_32:  nxt = by_w[1];
      default: nxt = by_w[2];
    endcase
    nxt = nxt & keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/perm2t_chk.sv
module perm2t_chk #(
  parameter int DW = 512,
  parameter int ML = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    elem_sz,
  input logic [1:0]    vec_len,
  input logic          mask_on,
  input logic          zero_fill,
  input logic          bcast,
  input logic [ML-1:0] lane_mask,
  input logic [DW-1:0] idx_vec,
  input logic [DW-1:0] dst_in,
  input logic [DW-1:0] src_b,
  input logic          out_valid,
  input logic [DW-1:0] result
);
  localparam int QW = DW / 4;

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_fall_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_short_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_len == 2'd0) |=> (result[DW-1:QW] == '0));

  p_all_zeroed_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_on && zero_fill && lane_mask == '0) |=> (result == '0));

  p_all_merged_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_on && !zero_fill && lane_mask == '0 && vec_len == 2'd2)
    |=> (result == $past(dst_in)));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

bind perm2t_unit perm2t_chk #(.DW(DW), .ML(ML)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .elem_sz   (elem_sz),
  .vec_len   (vec_len),
  .mask_on   (mask_on),
  .zero_fill (zero_fill),
  .bcast     (bcast),
  .lane_mask (lane_mask),
  .idx_vec   (idx_vec),
  .dst_in    (dst_in),
  .src_b     (src_b),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/sim_perm2t_unit.sv
`timescale 1ns/1ps
module sim_perm2t_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   elem_sz = '0;
  logic [1:0]   vec_len = '0;
  logic         mask_on = 1'b0;
  logic         zero_fill = 1'b0;
  logic         bcast = 1'b0;
  logic [31:0]  lane_mask = '0;
  logic [511:0] idx_vec = '0;
  logic [511:0] dst_in = '0;
  logic [511:0] src_b = '0;
  logic         out_valid;
  logic [511:0] result;

  int total = 0;
  int fails = 0;
  logic [511:0] exp_q [$];
  string        tag_q [$];
  logic [511:0] last_exp = '0;

  always #2.5 clk = ~clk;

  perm2t_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem_sz(elem_sz),
    .vec_len(vec_len), .mask_on(mask_on), .zero_fill(zero_fill),
    .bcast(bcast), .lane_mask(lane_mask), .idx_vec(idx_vec),
    .dst_in(dst_in), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [511:0] rnd512();
    logic [511:0] r = '0;
    for (int k = 0; k < 16; k++) r = {r[479:0], $urandom()};
    return r;
  endfunction

  function automatic logic [511:0] ref_model(int es, int vl, bit men, bit zm,
      bit bc, logic [31:0] mk, logic [511:0] ix, logic [511:0] d, logic [511:0] s);
    int ew, vb, n, pb, pos;
    logic [511:0] em, ie, el, res;
    if (es > 2) es = 2;
    if (vl > 2) vl = 2;
    ew = 16 << es;
    vb = 128 << vl;
    n = vb / ew;
    pb = 0;
    while ((1 << pb) < n) pb++;
    em = (512'd1 << ew) - 512'd1;
    res = '0;
    for (int j = 0; j < n; j++) begin
      ie = (ix >> (j * ew)) & em;
      pos = int'(ie[15:0]) & (n - 1);
      if (ie[pb]) el = (bc && es != 0) ? (s & em) : ((s >> (pos * ew)) & em);
      else        el = (d >> (pos * ew)) & em;
      if (men && !mk[j]) el = zm ? '0 : ((d >> (j * ew)) & em);
      res = res | (el << (j * ew));
    end
    return res;
  endfunction

  task automatic send_raw(int es, int vl, bit men, bit zm, bit bc,
      logic [31:0] mk, logic [511:0] ix, logic [511:0] d, logic [511:0] s,
      logic [511:0] ex, string tag);
    @(negedge clk);
    in_valid = 1'b1; elem_sz = 2'(es); vec_len = 2'(vl);
    mask_on = men; zero_fill = zm; bcast = bc; lane_mask = mk;
    idx_vec = ix; dst_in = d; src_b = s;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  task automatic send(int es, int vl, bit men, bit zm, bit bc,
      logic [31:0] mk, logic [511:0] ix, logic [511:0] d, logic [511:0] s, string tag);
    send_raw(es, vl, men, zm, bc, mk, ix, d, s,
             ref_model(es, vl, men, zm, bc, mk, ix, d, s), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(bit ok, string tag, logic [511:0] act, logic [511:0] ex);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  // Monitor: pops one expectation for every valid result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", result, '0);
      end else begin
        logic [511:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        last_exp = ex;
        check(result === ex, tg, result, ex);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [511:0] d, s, ix, ex;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset out_valid", {511'd0, out_valid}, '0);
    check(result === '0, "R1 reset result", result, '0);
    @(negedge clk);
    rst = 1'b0;

    // R3 R4 R10 hand-computed: 32-bit elements, 128-bit length
    d = rnd512(); s = rnd512();
    d[127:0] = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    s[127:0] = {32'hD0D0D0D0, 32'hC0C0C0C0, 32'hB0B0B0B0, 32'hA0A0A0A0};
    ix = rnd512();
    ix[127:0] = {32'h7FFFFFF9, 32'd6, 32'd4, 32'd3};
    ex = '0;
    ex[127:0] = {32'h22222222, 32'hC0C0C0C0, 32'hA0A0A0A0, 32'h44444444};
    send_raw(1, 0, 0, 0, 0, '0, ix, d, s, ex, "R3 R4 R10 directed 32b/128");

    // R2 R3 R4 R9: every size and length, back to back
    for (int e = 0; e < 3; e++)
      for (int v = 0; v < 3; v++)
        send(e, v, 0, 0, 0, $urandom(), rnd512(), rnd512(), rnd512(), "R2 R3 R4 R9 plain");
    // R5 merge masking with junk mask bits above the element count
    for (int e = 0; e < 3; e++)
      for (int v = 0; v < 3; v++)
        send(e, v, 1, 0, 0, $urandom(), rnd512(), rnd512(), rnd512(), "R5 R9 merge");
    // R6 zero masking
    for (int e = 0; e < 3; e++)
      for (int v = 0; v < 3; v++)
        send(e, v, 1, 1, 0, $urandom(), rnd512(), rnd512(), rnd512(), "R6 R9 zero");
    // R6 mask disabled ignores mask bits
    send(1, 2, 0, 1, 0, 32'h0, rnd512(), rnd512(), rnd512(), "R6 mask off");
    // R7 broadcast
    for (int e = 1; e < 3; e++)
      for (int v = 0; v < 3; v++)
        send(e, v, 0, 0, 1, '0, rnd512(), rnd512(), rnd512(), "R7 broadcast");
    send(2, 2, 1, 0, 1, $urandom(), rnd512(), rnd512(), rnd512(), "R7 broadcast merge");
    // R8 broadcast ignored for 16-bit elements
    for (int v = 0; v < 3; v++)
      send(0, v, 0, 0, 1, '0, rnd512(), rnd512(), rnd512(), "R8 no broadcast 16b");
    // R10 duplicated indices with junk upper bits
    for (int e = 0; e < 3; e++) begin
      int ew = 16 << e;
      logic [511:0] dup = '0;
      for (int j = 0; j < 512 / ew; j++)
        dup = dup | ((512'hFFFF_FFFF_FFFF_FFE5 & ((512'd1 << ew) - 512'd1)) << (j * ew));
      send(e, 2, 0, 0, 0, '0, dup, rnd512(), rnd512(), "R10 duplicates");
    end
    // R2 codes 3 behave as widest
    send(3, 3, 1, 1, 0, $urandom(), rnd512(), rnd512(), rnd512(), "R2 code 3");
    idle();

    // R11 hold and R1 out_valid low while idle
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R1 idle out_valid", {511'd0, out_valid}, '0);
    check(result === last_exp, "R11 hold", result, last_exp);
    check(exp_q.size() == 0, "R1 all results seen", 512'(exp_q.size()), '0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule